// File: doc/BRIEF.md
# Toffoli Cascade Evaluator

This block computes the outputs of a reversible circuit described as an ordered list of multi-control Toffoli gates. Software or a neighbouring engine appends gates one at a time through a write port; each gate holds a control mask over the signal lines and the index of one target line. A start strobe with an input vector makes the block build the line vector and then apply the stored gates in list order, one gate per clock. When the last gate has been applied, the block raises a one-cycle completion pulse. The final line vector then stays on the output until the next start or reset.

The line vector has 2*N_IN + N_OUT lines. Bits [N_IN-1:0] carry the inputs as given. Bits [2*N_IN-1:N_IN] carry the same inputs inverted. The top N_OUT bits are output lines, which start at zero. An exclusive-or sum of products maps onto this vector directly: one gate per cube and per output that the cube feeds, with controls on the literal lines and the target on that output's line. Once the cascade has run, each output line holds the XOR of its cubes.

Top module: `tce_top`

## Requirements
- R1: When start is high and the block is idle, the next clock loads lines_out as {N_OUT zeros, ~in_vec, in_vec}, with the positive copy in the low bits.
- R2: A gate inverts its target line only when every line set in its control mask is 1. All other lines pass through unchanged.
- R3: A gate with an all-zero control mask inverts its target every time it is applied.
- R4: Gates are applied in the order they were written, one per clock. With K gates stored, done is seen K+1 cycles after the clock that takes start.
- R5: done is high for a single cycle, in the cycle after the last gate is applied, and lines_out holds its value afterwards.
- R6: A gate whose target bit is also set in its own control mask is rejected. It sets err, leaves lines_out unchanged for that step, and the gates after it still run. err is cleared at each accepted start and stays 0 when no gate is rejected.
- R7: Starting with no gates stored raises done on the next cycle, and lines_out holds the initial line vector.
- R8: Reset clears the stored gate count and lines_out, and drops busy and done.
- R9: A write that arrives when DEPTH gates are already stored is ignored.
- R10: A start that arrives while busy is high is ignored, and the run in progress finishes with its original input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Append a gate to the list |
| wr_ctrl | input | 2*N_IN+N_OUT | Control mask of the gate being written |
| wr_tgt | input | clog2(2*N_IN+N_OUT) | Target line index of the gate being written |
| start | input | 1 | Begin evaluation using in_vec |
| in_vec | input | N_IN | Input vector |
| busy | output | 1 | Gates are being applied |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | At least one gate was rejected in this run |
| lines_out | output | 2*N_IN+N_OUT | Current line vector |

## Verification
Two situations are hard to reach from the ports: a stored list that fills the memory exactly, and a start that arrives in the middle of a run. The bench writes one gate more than the memory holds, choosing inverters so that the extra gate would flip a visible output. It also raises start again while busy is high, using an input vector whose result differs from the one in progress. A self-referencing gate is placed ahead of a valid one, which shows that a rejected gate leaves the lines unchanged and that the gates after it still run. The main ESOP is checked against a separate XOR-of-cubes evaluation for every input vector.

// File: rtl/tce_pkg.sv
package tce_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} tce_state_e;
endpackage

// File: rtl/tce_gate_store.sv
module tce_gate_store #(
  parameter int L     = 8,
  parameter int TW    = 3,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic [L-1:0]  wr_ctrl,
  input  logic [TW-1:0] wr_tgt,
  input  logic [AW-1:0] rd_idx,
  output logic [L-1:0]  rd_ctrl,
  output logic [TW-1:0] rd_tgt,
  output logic [CW-1:0] count
);
  logic [L-1:0]  ctrl_mem [DEPTH];
  logic [TW-1:0] tgt_mem  [DEPTH];
  logic          accept;

  assign accept = wr_req && (int'(count) < DEPTH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (accept) begin
      count <= count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      ctrl_mem[AW'(count)] <= wr_ctrl;
      tgt_mem[AW'(count)]  <= wr_tgt;
    end
  end

  assign rd_ctrl = ctrl_mem[rd_idx];
  assign rd_tgt  = tgt_mem[rd_idx];
endmodule

// File: rtl/tce_gate_apply.sv
module tce_gate_apply #(
  parameter int L  = 8,
  parameter int TW = 3
) (
  input  logic [L-1:0]  lines_in,
  input  logic [L-1:0]  ctrl,
  input  logic [TW-1:0] tgt,
  output logic [L-1:0]  lines_next,
  output logic [L-1:0]  tgt_onehot,
  output logic          reject,
  output logic          fire
);
  function automatic logic [L-1:0] line_select(input logic [TW-1:0] t);
    logic [L-1:0] m;
    m = '0;
    for (int i = 0; i < L; i++) begin
      if (int'(t) == i) m[i] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic gate_legal(input logic [L-1:0] c, input logic [L-1:0] sel);
    return (sel != '0) && ((c & sel) == '0);
  endfunction

  function automatic logic controls_met(input logic [L-1:0] v, input logic [L-1:0] c);
    return (v & c) == c;
  endfunction

  assign tgt_onehot = line_select(tgt);
  assign reject     = !gate_legal(ctrl, tgt_onehot);
  assign fire       = !reject && controls_met(lines_in, ctrl);
  assign lines_next = fire ? (lines_in ^ tgt_onehot) : lines_in;
endmodule

// File: rtl/tce_top.sv
module tce_top #(
  parameter int N_IN  = 3,
  parameter int N_OUT = 2,
  parameter int DEPTH = 8,
  localparam int L    = 2 * N_IN + N_OUT,
  localparam int TW   = $clog2(L),
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [L-1:0]    wr_ctrl,
  input  logic [TW-1:0]   wr_tgt,
  input  logic            start,
  input  logic [N_IN-1:0] in_vec,
  output logic            busy,
  output logic            done,
  output logic            err,
  output logic [L-1:0]    lines_out
);
  import tce_pkg::*;

  tce_state_e    state;
  logic [AW-1:0] idx;
  logic [CW-1:0] gate_count;
  logic [L-1:0]  cur_ctrl;
  logic [TW-1:0] cur_tgt;
  logic [L-1:0]  step_next;
  logic [L-1:0]  step_onehot;
  logic          step_reject;
  logic          step_fire;
  logic          start_take;
  logic          last_step;

  function automatic logic [L-1:0] setup_lines(input logic [N_IN-1:0] x);
    return {{N_OUT{1'b0}}, ~x, x};
  endfunction

  assign busy       = (state == ST_RUN);
  assign start_take = start && !busy;
  assign last_step  = (CW'(idx) + 1'b1) == gate_count;

  tce_gate_store #(.L(L), .TW(TW), .DEPTH(DEPTH)) store_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_req  (wr_en && !busy),
    .wr_ctrl (wr_ctrl),
    .wr_tgt  (wr_tgt),
    .rd_idx  (idx),
    .rd_ctrl (cur_ctrl),
    .rd_tgt  (cur_tgt),
    .count   (gate_count)
  );

  tce_gate_apply #(.L(L), .TW(TW)) apply_i (
    .lines_in   (lines_out),
    .ctrl       (cur_ctrl),
    .tgt        (cur_tgt),
    .lines_next (step_next),
    .tgt_onehot (step_onehot),
    .reject     (step_reject),
    .fire       (step_fire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      lines_out <= '0;
      idx       <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start_take) begin
            lines_out <= setup_lines(in_vec);
            idx       <= '0;
            err       <= 1'b0;
            if (gate_count == '0) done  <= 1'b1;
            else                  state <= ST_RUN;
          end
        end
        ST_RUN: begin
          lines_out <= step_next;
          if (step_reject) err <= 1'b1;
          if (last_step) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tce_checker.sv
module tce_checker #(
  parameter int N_IN  = 3,
  parameter int N_OUT = 2,
  parameter int DEPTH = 8,
  localparam int L    = 2 * N_IN + N_OUT,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [L-1:0]  lines_out,
  input logic [L-1:0]  step_onehot,
  input logic          step_reject,
  input logic [CW-1:0] gate_count
);
  a_r1_setup: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (lines_out[L-1:2*N_IN] == '0) &&
                         (lines_out[2*N_IN-1:N_IN] == ~lines_out[N_IN-1:0]));

  a_r2_single_flip: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $countones(lines_out ^ $past(lines_out)) <= 1);

  a_r2_target_only: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((lines_out ^ $past(lines_out)) & ~$past(step_onehot)) == '0);

  a_r6_reject_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && step_reject) |=> $stable(lines_out));

  a_r5_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(gate_count) <= DEPTH);
endmodule

bind tce_top tce_checker #(.N_IN(N_IN), .N_OUT(N_OUT), .DEPTH(DEPTH)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .lines_out   (lines_out),
  .step_onehot (step_onehot),
  .step_reject (step_reject),
  .gate_count  (gate_count)
);

// File: tb/tce_top_tb.sv
module tce_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_IN = 3, N_OUT = 2, DEPTH = 8;
  localparam int L = 2 * N_IN + N_OUT;
  localparam int TW = $clog2(L);
  localparam int NCUBE = 4;
  // cube: [2:0] positive literals, [5:3] negated literals, [7:6] outputs fed
  localparam logic [7:0] CUBES [NCUBE] = '{
    8'b01_000_011,   // x0 x1           -> out0
    8'b11_100_000,   // ~x2             -> out0, out1
    8'b10_010_101,   // x0 ~x1 x2       -> out1
    8'b10_000_000    // constant 1      -> out1
  };

  logic clk = 0, rst_n = 0, wr_en = 0, start = 0;
  logic [L-1:0] wr_ctrl = '0;
  logic [TW-1:0] wr_tgt = '0;
  logic [N_IN-1:0] in_vec = '0;
  logic busy, done, err;
  logic [L-1:0] lines_out;
  int checks = 0, failures = 0, ngates = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tce_top #(.N_IN(N_IN), .N_OUT(N_OUT), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ctrl(wr_ctrl), .wr_tgt(wr_tgt),
    .start(start), .in_vec(in_vec), .busy(busy), .done(done), .err(err),
    .lines_out(lines_out));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [N_OUT-1:0] esop_ref(input logic [N_IN-1:0] x);
    logic [N_OUT-1:0] o = '0;
    for (int c = 0; c < NCUBE; c++) begin
      logic hit;
      hit = ((x & CUBES[c][2:0]) == CUBES[c][2:0]) && ((~x & CUBES[c][5:3]) == CUBES[c][5:3]);
      for (int k = 0; k < N_OUT; k++) if (CUBES[c][6+k] && hit) o[k] = ~o[k];
    end
    return o;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
    ngates = 0;
  endtask

  task automatic put_gate(input logic [L-1:0] c, input int t);
    @(negedge clk); wr_en = 1; wr_ctrl = c; wr_tgt = TW'(t);
    @(negedge clk); wr_en = 0;
    ngates++;
  endtask

  task automatic run(input logic [N_IN-1:0] x, input logic restart, output int lat);
    @(negedge clk); start = 1; in_vec = x;
    @(negedge clk);
    if (restart) begin start = 1; in_vec = ~x; @(negedge clk); end
    start = 0;
    lat = restart ? 2 : 1;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int lat;
    do_reset();
    // R8: reset state
    check("R8 lines", lines_out, 0);
    check("R8 busy/done", {busy, done}, 0);
    // load the ESOP: one gate per cube per output
    for (int c = 0; c < NCUBE; c++)
      for (int k = 0; k < N_OUT; k++)
        if (CUBES[c][6+k]) put_gate({2'b00, CUBES[c][5:3], CUBES[c][2:0]}, 2*N_IN + k);
    // R1 R2 R3 R4 R5 R6: walk all inputs against the XOR-of-cubes reference
    for (int x = 0; x < (1 << N_IN); x++) begin
      logic [N_IN-1:0] xv = N_IN'(x);
      run(xv, 1'b0, lat);
      check("R4 latency", lat, ngates + 1);
      check("R2 R3 lines", lines_out, {esop_ref(xv), ~xv, xv});
      check("R6 no err", err, 0);
      @(negedge clk);
      check("R5 pulse", done, 0);
      check("R5 hold", lines_out, {esop_ref(xv), ~xv, xv});
    end
    // R10: second start while busy is ignored
    run(3'b011, 1'b1, lat);
    check("R10 lines", lines_out, {esop_ref(3'b011), 3'b100, 3'b011});
    // R8 R7: reset clears list; start with no gates returns the initial vector
    do_reset();
    check("R8 reset lines", lines_out, 0);
    run(3'b101, 1'b0, lat);
    check("R7 latency", lat, 1);
    check("R7 R1 lines", lines_out, 8'b00_010_101);
    // R6: self-controlled gate rejected, later gate still applied
    put_gate(8'b0100_0001, 6);
    put_gate(8'b0000_0000, 7);
    run(3'b001, 1'b0, lat);
    check("R6 lines", lines_out, 8'b10_110_001);
    check("R6 err", err, 1);
    // R9: DEPTH+1 inverters on line 6; the last one is dropped
    do_reset();
    for (int g = 0; g < DEPTH + 1; g++) put_gate('0, 6);
    run(3'b000, 1'b0, lat);
    check("R9 latency", lat, DEPTH + 1);
    check("R9 R3 lines", lines_out, 8'b00_111_000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule